// File: doc/BRIEF.md
# Compare Output Pin Unit

This block keeps the one-bit output-compare state of a timer channel and drives a device pin from it. The timer core sends a one-cycle compare-match pulse. On that pulse the unit changes the state bit as a two-bit mode field selects: no action, toggle, clear or set. Software can get the same update without a match by pulsing a force strobe, but only while the timer is in a non-PWM mode.

A port-override multiplexer chooses the pin's drive value. When the mode field is non-zero, the state bit drives the pin. When the mode field is zero, the general-purpose port data bit drives it. The mode field has no shadow copy, so the pin source changes in the same cycle as the field. The port's data-direction bit alone controls the pin output enable. This lets software preload the state bit with a forced set or clear while the pin is still an input, and then turn the output on at a known level.

Top module: `cmp_out_pin`

## Requirements
- R1: After the active-low asynchronous reset, the state bit is 0. With mode 01 selected, output enabled and no event, pin_o reads 0.
- R2: With mode 00, a compare match or force leaves the state bit unchanged.
- R3: With mode 01, each event inverts the state bit at the clock edge where the event is sampled.
- R4: With mode 10, an event clears the state bit at that clock edge.
- R5: With mode 11, an event sets the state bit at that clock edge.
- R6: When the mode field is non-zero, pin_o equals the state bit. When the mode field is 00, pin_o equals port_data_i.
- R7: pin_oe_o always equals port_dir_i (1 = output), whatever the mode and whatever pwm_i is.
- R8: The override selection and the compare-match action do not depend on pwm_i.
- R9: A write to the mode field changes the pin source in the same cycle. The new mode changes the state bit only at the next event.
- R10: With pwm_i = 0, a force_i pulse applies the selected action with no compare match.
- R11: With pwm_i = 1, force_i has no effect on the state bit.
- R12: The state bit can be forced to a level while port_dir_i = 0. That level appears on pin_o once port_dir_i becomes 1.
- R13: A compare match and a force in the same cycle count as one event, so mode 01 toggles only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| match_i | input | 1 | Compare-match pulse from the timer core |
| mode_i | input | 2 | Compare output mode: 00 none, 01 toggle, 10 clear, 11 set |
| force_i | input | 1 | Force-compare strobe |
| pwm_i | input | 1 | 1 = timer is in a PWM mode |
| port_data_i | input | 1 | General-purpose port data bit |
| port_dir_i | input | 1 | Port direction bit, 1 = output |
| pin_o | output | 1 | Pin drive value |
| pin_oe_o | output | 1 | Pin output enable |

## Verification
The assertions check on every cycle that the state bit changes only on a qualifying event. They also check that toggle, clear and set give the required next value, that a force in a PWM mode is ignored, and that the pin follows the state bit whenever the override is active. Some behaviours need a sequence of stimulus and are shown only by the bench scenarios: the reset level seen at the pin, preloading the state bit behind a disabled output, a mode write that moves the pin source at once but waits for the next event to touch the state, and a match coinciding with a force.

// File: rtl/cmp_out_pkg.sv
package cmp_out_pkg;
  localparam int MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    CM_OFF = 2'b00,
    CM_TOG = 2'b01,
    CM_CLR = 2'b10,
    CM_SET = 2'b11
  } cmp_mode_e;
endpackage

// File: rtl/cmp_act_dec.sv
module cmp_act_dec
  import cmp_out_pkg::*;
(
  input  logic              match_i,
  input  logic              force_i,
  input  logic              pwm_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              state_i,
  output logic              load_o,
  output logic              next_o
);
  logic      evt;
  cmp_mode_e mode;

  // force only counts outside PWM; match+force is a single event
  assign evt  = match_i | (force_i & ~pwm_i);
  assign mode = cmp_mode_e'(mode_i);

  always_comb begin
    load_o = 1'b0;
    next_o = state_i;
    if (evt) begin
      unique case (mode)
        CM_TOG: begin load_o = 1'b1; next_o = ~state_i; end
        CM_CLR: begin load_o = 1'b1; next_o = 1'b0;     end
        CM_SET: begin load_o = 1'b1; next_o = 1'b1;     end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cmp_state_reg.sv
module cmp_state_reg #(
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic d_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= RESET_VAL;
    else if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/pin_override_mux.sv
module pin_override_mux
  import cmp_out_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  input  logic              state_i,
  input  logic              port_data_i,
  input  logic              port_dir_i,
  output logic              pin_o,
  output logic              pin_oe_o
);
  logic ovr;

  assign ovr      = (cmp_mode_e'(mode_i) != CM_OFF);
  assign pin_o    = ovr ? state_i : port_data_i;
  assign pin_oe_o = port_dir_i;
endmodule

// File: rtl/cmp_out_pin.sv
module cmp_out_pin
  import cmp_out_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              match_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              force_i,
  input  logic              pwm_i,
  input  logic              port_data_i,
  input  logic              port_dir_i,
  output logic              pin_o,
  output logic              pin_oe_o
);
  logic state_q;
  logic load;
  logic next;

  cmp_act_dec u_dec (
    .match_i (match_i),
    .force_i (force_i),
    .pwm_i   (pwm_i),
    .mode_i  (mode_i),
    .state_i (state_q),
    .load_o  (load),
    .next_o  (next)
  );

  cmp_state_reg #(.RESET_VAL(1'b0)) u_state (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .d_i    (next),
    .q_o    (state_q)
  );

  pin_override_mux u_mux (
    .mode_i      (mode_i),
    .state_i     (state_q),
    .port_data_i (port_data_i),
    .port_dir_i  (port_dir_i),
    .pin_o       (pin_o),
    .pin_oe_o    (pin_oe_o)
  );
endmodule

// File: rtl/cmp_out_pin_chk.sv
module cmp_out_pin_chk
  import cmp_out_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              match_i,
  input logic [MODE_W-1:0] mode_i,
  input logic              force_i,
  input logic              pwm_i,
  input logic              pin_o,
  input logic              state_q
);
  logic evt;
  assign evt = match_i || (force_i && !pwm_i);

  p_hold_no_action_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!evt || mode_i == 2'b00) |=> $stable(state_q));

  p_toggle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt && mode_i == 2'b01) |=> (state_q != $past(state_q)));

  p_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt && mode_i == 2'b10) |=> !state_q);

  p_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt && mode_i == 2'b11) |=> state_q);

  p_pin_from_state_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != 2'b00) |-> (pin_o == state_q));

  p_force_pwm_ignored_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (force_i && pwm_i && !match_i) |=> $stable(state_q));
endmodule

bind cmp_out_pin cmp_out_pin_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .match_i (match_i),
  .mode_i  (mode_i),
  .force_i (force_i),
  .pwm_i   (pwm_i),
  .pin_o   (pin_o),
  .state_q (state_q)
);

// File: tb/sim_cmp_out_pin.sv
module sim_cmp_out_pin;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       match = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       frc = 1'b0;
  logic       pwm = 1'b0;
  logic       pdat = 1'b0;
  logic       pdir = 1'b0;
  logic       pin;
  logic       oe;

  typedef struct {
    logic  pin;
    logic  oe;
    string tag;
  } exp_t;

  exp_t  sb_q[$];
  int    checks = 0;
  int    errors = 0;
  logic  model_state = 1'b0;
  bit    done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  cmp_out_pin u0 (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .match_i     (match),
    .mode_i      (mode),
    .force_i     (frc),
    .pwm_i       (pwm),
    .port_data_i (pdat),
    .port_dir_i  (pdir),
    .pin_o       (pin),
    .pin_oe_o    (oe)
  );

  // drive one cycle of stimulus; push the outputs expected after the next edge
  task automatic drive(input logic m, input logic [1:0] md, input logic f,
                       input logic pw, input logic d, input logic dir,
                       input string tag);
    exp_t e;
    @(negedge clk);
    match = m; mode = md; frc = f; pwm = pw; pdat = d; pdir = dir;
    if (m || (f && !pw)) begin
      case (md)
        2'b01: model_state = ~model_state;
        2'b10: model_state = 1'b0;
        2'b11: model_state = 1'b1;
        default: ;
      endcase
    end
    e.pin = (md != 2'b00) ? model_state : d;
    e.oe  = dir;
    e.tag = tag;
    sb_q.push_back(e);
  endtask

  // monitor: compare after each edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        checks++;
        if (pin !== e.pin || oe !== e.oe) begin
          errors++;
          $display("FAIL %s: pin=%b oe=%b expected pin=%b oe=%b",
                   e.tag, pin, oe, e.pin, e.oe);
        end
      end
    end
  end

  initial begin
    #(20 * 5000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset level visible through override
    drive(0, 2'b01, 0, 0, 1, 1, "R1 reset state");
    // R6: no override -> port data
    drive(0, 2'b00, 0, 0, 1, 1, "R6 port data 1");
    drive(0, 2'b00, 0, 0, 0, 1, "R6 port data 0");
    // R2: mode 00 match does nothing
    drive(1, 2'b00, 0, 0, 1, 1, "R2 match mode 00");
    drive(0, 2'b11, 0, 0, 1, 1, "R2 state still 0");
    // R5 set, R3 toggle, R4 clear
    drive(1, 2'b11, 0, 0, 0, 1, "R5 set on match");
    drive(1, 2'b01, 0, 0, 0, 1, "R3 toggle to 0");
    drive(1, 2'b01, 0, 0, 0, 1, "R3 toggle to 1");
    drive(1, 2'b10, 0, 0, 1, 1, "R4 clear on match");
    // R9: mode write moves source now, state waits for event
    drive(0, 2'b00, 0, 0, 1, 1, "R9 source back to port");
    drive(0, 2'b11, 0, 0, 1, 1, "R9 override now, state 0");
    drive(1, 2'b11, 0, 0, 1, 1, "R9 set at next match");
    // R8: pwm does not change override or match action
    drive(0, 2'b10, 0, 1, 0, 1, "R8 override in pwm");
    drive(1, 2'b01, 0, 1, 1, 1, "R8 match toggles in pwm");
    // R7: oe from direction only
    drive(0, 2'b11, 0, 1, 0, 0, "R7 oe off with override");
    drive(0, 2'b00, 0, 0, 1, 0, "R7 oe off no override");
    drive(0, 2'b00, 0, 1, 1, 1, "R7 oe on");
    // R10: force in non-pwm
    drive(0, 2'b01, 1, 0, 0, 1, "R10 force toggles");
    drive(0, 2'b10, 1, 0, 1, 1, "R10 force clears");
    // R11: force ignored in pwm
    drive(0, 2'b11, 1, 1, 0, 1, "R11 force in pwm ignored");
    drive(0, 2'b11, 0, 1, 0, 1, "R11 state still 0");
    // R12: preload behind disabled output
    drive(0, 2'b11, 1, 0, 0, 0, "R12 preload set, oe off");
    drive(0, 2'b11, 0, 0, 0, 1, "R12 enable shows preload");
    // R13: match+force together toggle once
    drive(1, 2'b01, 1, 0, 1, 1, "R13 single toggle");
    drive(0, 2'b01, 0, 0, 1, 1, "R13 state held at 0");
    drive(0, 2'b00, 0, 0, 0, 1, "idle");
    repeat (3) @(posedge clk);
    #3;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule